// File: doc/BRIEF.md
# TPC Command Pattern Generator

This block decides the transmit power control bit that a downlink control channel carries in each slot. Every slot strobe yields one registered bit (1 = power up, 0 = power down) together with a one-cycle valid pulse. A mode select picks the pattern:

- a closed-loop decision driven by an externally supplied signed power error (measured minus target, in hundredths of a dB);
- strict up/down alternation;
- a constant up pattern;
- a constant down pattern;
- a frame-aligned pattern of ten up bits followed by ten down bits.

An algorithm select input chooses between per-slot combining (one) and five-slot-set combining (two) at the receiving terminal. With algorithm two, the closed-loop mode leaves a ±0.75 dB window without net correction.

In alternating mode, one-shot step requests insert a single 1 dB up or down command. With algorithm one, the command is a single inserted bit. With algorithm two, it is a full five-slot set of identical bits aligned to the set grid. Frames start on a frame strobe that always coincides with a slot strobe. Five-slot sets and the ten/ten pattern are counted from the most recent frame start.

Top module: `tpc_pattern_gen`

## Requirements
- R1: `tpc_vld` is high for exactly the one clock cycle after each cycle in which `slot_stb` is high. `tpc_bit` changes only in that cycle and holds its value otherwise. After reset `tpc_vld` = 0 and `tpc_bit` = 0.
- R2: With mode code 0 (closed loop) and `algo_two` = 0, the bit is 1 when `pwr_err` is negative and 0 when `pwr_err` is zero or positive.
- R3: With mode code 0 and `algo_two` = 1, an error above +75 gives 0 and an error below -75 gives 1. An error from -75 to +75 inclusive gives the next bit of the shared alternation sequence.
- R4: Mode code 1 (alternating) emits the shared alternation sequence, which starts with 1 after reset. The sequence advances only on slots that actually emit an alternation bit, so its phase is held while other modes or injected steps are active.
- R5: Mode code 2 always emits 1 and mode code 3 always emits 0. Codes 5 to 7 behave as code 3.
- R6: Mode code 4 emits 1 for slot indices 0 to 9 and 0 for indices 10 to 19, repeating every 20 slots. The slot index restarts at 0 on every slot that carries `frame_stb`.
- R7: With `algo_two` = 0 in alternating mode, an accepted step request makes the next slot carry the requested bit in place of the alternation bit. Alternation then resumes where it paused.
- R8: With `algo_two` = 1 in alternating mode, an accepted step waits for the next slot whose set position (slot index from the last frame start, modulo 5) is 0. It then emits five identical bits of the requested direction, after which alternation resumes where it paused.
- R9: Step requests are ignored outside alternating mode and while a step is pending or being emitted. When `step_up_req` and `step_dn_req` are accepted in the same cycle, the up request wins.
- R10: Leaving alternating mode, even for a single cycle, discards a pending step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_stb | input | 1 | One-cycle pulse marking each slot |
| frame_stb | input | 1 | Frame start, only valid together with slot_stb |
| mode_sel | input | 3 | Pattern mode: 0 closed loop, 1 alternating, 2 all up, 3 all down, 4 ten/ten |
| algo_two | input | 1 | 1 selects algorithm two, 0 selects algorithm one |
| step_up_req | input | 1 | One-shot request for a 1 dB up step |
| step_dn_req | input | 1 | One-shot request for a 1 dB down step |
| pwr_err | input | 16 | Signed measured-minus-target power, 0.01 dB units |
| tpc_bit | output | 1 | Power control bit, 1 = up |
| tpc_vld | output | 1 | One-cycle pulse after each slot strobe |

## Verification
The bench probes the deadband edges at ±75 and ±76, the zero error, and the extremes of the error range. A sign or comparison slip would flip a bit there, or would alternate where a fixed correction is due. It also follows the alternation phase across mode changes, injected steps and deadband slots. A design that advanced the phase on every slot would emit inverted bits when alternating mode resumes. Step tests cover the wait for set position 0 and the five-bit burst, requests made outside alternating mode, a request discarded by a brief mode change, and simultaneous up and down requests. Any of these would leak a stray up or down bit if handled wrongly. The ten/ten pattern is run through a full wrap and a frame restart that arrives in the middle of the down run.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  typedef enum logic [2:0] {
    MODE_ACTIVE = 3'd0,
    MODE_ALT    = 3'd1,
    MODE_UP     = 3'd2,
    MODE_DOWN   = 3'd3,
    MODE_TEN    = 3'd4
  } tpc_mode_e;

  localparam logic TPC_UP = 1'b1;
  localparam logic TPC_DN = 1'b0;

endpackage

// File: rtl/tpc_slot_timer.sv
module tpc_slot_timer #(
  parameter int SET_LEN = 5,
  parameter int RUN_LEN = 10,
  localparam int SET_W  = (SET_LEN > 1) ? $clog2(SET_LEN) : 1,
  localparam int PER    = 2 * RUN_LEN,
  localparam int RUN_W  = $clog2(PER)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_stb,
  input  logic             frame_stb,
  output logic [SET_W-1:0] set_pos,
  output logic             run_up
);

  logic [SET_W-1:0] pos_q, pos_n;
  logic [RUN_W-1:0] run_q, run_n, cur_run;
  logic             frame_hit;

  assign frame_hit = slot_stb & frame_stb;

  always_comb begin
    set_pos = frame_hit ? '0 : pos_q;
    cur_run = frame_hit ? '0 : run_q;
    run_up  = (cur_run < RUN_W'(RUN_LEN));
    pos_n   = pos_q;
    run_n   = run_q;
    if (slot_stb) begin
      pos_n = (set_pos == SET_W'(SET_LEN - 1)) ? '0 : set_pos + 1'b1;
      run_n = (cur_run == RUN_W'(PER - 1))     ? '0 : cur_run + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      run_q <= '0;
    end else begin
      pos_q <= pos_n;
      run_q <= run_n;
    end
  end

endmodule

// File: rtl/tpc_active_dec.sv
module tpc_active_dec #(
  parameter int ERR_W    = 16,
  parameter int DEADBAND = 75
) (
  input  logic signed [ERR_W-1:0] pwr_err,
  input  logic                    algo_two,
  output logic                    want_bit,
  output logic                    in_band
);
  import tpc_pkg::*;

  localparam logic signed [ERR_W-1:0] BAND_HI = ERR_W'(DEADBAND);
  localparam logic signed [ERR_W-1:0] BAND_LO = -ERR_W'(DEADBAND);

  always_comb begin
    want_bit = (pwr_err < 0) ? TPC_UP : TPC_DN;
    in_band  = algo_two && (pwr_err >= BAND_LO) && (pwr_err <= BAND_HI);
  end

endmodule

// File: rtl/tpc_step_ctrl.sv
module tpc_step_ctrl #(
  parameter int SET_LEN = 5,
  localparam int SET_W  = (SET_LEN > 1) ? $clog2(SET_LEN) : 1,
  localparam int CNT_W  = $clog2(SET_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alt_mode,
  input  logic             algo_two,
  input  logic             slot_stb,
  input  logic [SET_W-1:0] set_pos,
  input  logic             step_up_req,
  input  logic             step_dn_req,
  output logic             inj_active,
  output logic             inj_bit
);

  logic             pend_q, pend_n;
  logic             dir_q, dir_n;
  logic             burst_q, burst_n;
  logic [CNT_W-1:0] bcnt_q, bcnt_n;
  logic             busy, start_ok;

  assign busy     = pend_q | burst_q;
  assign start_ok = pend_q && (!algo_two || set_pos == '0);

  always_comb begin
    inj_active = alt_mode && slot_stb && (burst_q || start_ok);
    inj_bit    = dir_q;
  end

  always_comb begin
    pend_n  = pend_q;
    dir_n   = dir_q;
    burst_n = burst_q;
    bcnt_n  = bcnt_q;
    if (!alt_mode) begin
      pend_n  = 1'b0;
      burst_n = 1'b0;
      bcnt_n  = '0;
    end else begin
      if (slot_stb) begin
        if (burst_q) begin
          if (bcnt_q == CNT_W'(SET_LEN - 1)) begin
            burst_n = 1'b0;
            bcnt_n  = '0;
          end else begin
            bcnt_n = bcnt_q + 1'b1;
          end
        end else if (start_ok) begin
          pend_n = 1'b0;
          if (algo_two && SET_LEN > 1) begin
            burst_n = 1'b1;
            bcnt_n  = CNT_W'(1);
          end
        end
      end
      if (!busy && (step_up_req || step_dn_req)) begin
        pend_n = 1'b1;
        dir_n  = step_up_req;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      dir_q   <= 1'b0;
      burst_q <= 1'b0;
      bcnt_q  <= '0;
    end else begin
      pend_q  <= pend_n;
      dir_q   <= dir_n;
      burst_q <= burst_n;
      bcnt_q  <= bcnt_n;
    end
  end

endmodule

// File: rtl/tpc_pattern_gen.sv
module tpc_pattern_gen #(
  parameter int ERR_W    = 16,
  parameter int DEADBAND = 75,
  parameter int SET_LEN  = 5,
  parameter int RUN_LEN  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_stb,
  input  logic             frame_stb,
  input  logic [2:0]       mode_sel,
  input  logic             algo_two,
  input  logic             step_up_req,
  input  logic             step_dn_req,
  input  logic [ERR_W-1:0] pwr_err,
  output logic             tpc_bit,
  output logic             tpc_vld
);
  import tpc_pkg::*;

  localparam int SET_W = (SET_LEN > 1) ? $clog2(SET_LEN) : 1;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [SET_W-1:0] set_pos;
  logic             run_up, want_bit, in_band, inj_active, inj_bit;
  logic             alt_q, alt_n, bit_q, bit_n, vld_q, adv, alt_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign alt_mode = (mode_sel == MODE_ALT);

  tpc_slot_timer #(.SET_LEN(SET_LEN), .RUN_LEN(RUN_LEN)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .slot_stb(slot_stb), .frame_stb(frame_stb),
    .set_pos(set_pos), .run_up(run_up)
  );

  tpc_active_dec #(.ERR_W(ERR_W), .DEADBAND(DEADBAND)) u_dec (
    .pwr_err(pwr_err), .algo_two(algo_two), .want_bit(want_bit), .in_band(in_band)
  );

  tpc_step_ctrl #(.SET_LEN(SET_LEN)) u_step (
    .clk(clk), .rst_n(rst_int_n), .alt_mode(alt_mode), .algo_two(algo_two),
    .slot_stb(slot_stb), .set_pos(set_pos), .step_up_req(step_up_req),
    .step_dn_req(step_dn_req), .inj_active(inj_active), .inj_bit(inj_bit)
  );

  always_comb begin
    adv   = 1'b0;
    bit_n = TPC_DN;
    case (mode_sel)
      MODE_ACTIVE: begin
        if (in_band) begin
          bit_n = alt_q;
          adv   = 1'b1;
        end else begin
          bit_n = want_bit;
        end
      end
      MODE_ALT: begin
        if (inj_active) begin
          bit_n = inj_bit;
        end else begin
          bit_n = alt_q;
          adv   = 1'b1;
        end
      end
      MODE_UP:   bit_n = TPC_UP;
      MODE_DOWN: bit_n = TPC_DN;
      MODE_TEN:  bit_n = run_up;
      default:   bit_n = TPC_DN;
    endcase
    alt_n = adv ? ~alt_q : alt_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      alt_q <= TPC_UP;
      bit_q <= TPC_DN;
      vld_q <= 1'b0;
    end else begin
      vld_q <= slot_stb;
      if (slot_stb) begin
        alt_q <= alt_n;
        bit_q <= bit_n;
      end
    end
  end

  assign tpc_bit = bit_q;
  assign tpc_vld = vld_q;

endmodule

// File: rtl/tpc_pattern_gen_chk.sv
module tpc_pattern_gen_chk #(
  parameter int ERR_W    = 16,
  parameter int DEADBAND = 75
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slot_stb,
  input logic             frame_stb,
  input logic [2:0]       mode_sel,
  input logic             algo_two,
  input logic [ERR_W-1:0] pwr_err,
  input logic             tpc_bit,
  input logic             tpc_vld
);

  logic signed [ERR_W-1:0] err_s;
  assign err_s = pwr_err;

  p_vld_after_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_stb |=> tpc_vld);
  p_vld_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_stb |=> !tpc_vld);
  p_bit_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_stb |=> $stable(tpc_bit));
  p_active_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && mode_sel == 3'd0 && !algo_two && err_s < 0) |=> tpc_bit);
  p_active_dn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && mode_sel == 3'd0 && !algo_two && err_s >= 0) |=> !tpc_bit);
  p_far_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && mode_sel == 3'd0 && algo_two && err_s > ERR_W'(DEADBAND)) |=> !tpc_bit);
  p_far_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && mode_sel == 3'd0 && algo_two && err_s < -ERR_W'(DEADBAND)) |=> tpc_bit);
  p_all_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && mode_sel == 3'd2) |=> tpc_bit);
  p_all_dn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && (mode_sel == 3'd3 || mode_sel > 3'd4)) |=> !tpc_bit);
  p_ten_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && frame_stb && mode_sel == 3'd4) |=> tpc_bit);

endmodule

bind tpc_pattern_gen tpc_pattern_gen_chk #(.ERR_W(ERR_W), .DEADBAND(DEADBAND)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .frame_stb(frame_stb),
  .mode_sel(mode_sel), .algo_two(algo_two), .pwr_err(pwr_err),
  .tpc_bit(tpc_bit), .tpc_vld(tpc_vld)
);

// File: tb/tb_tpc_pattern_gen.sv
module tb_tpc_pattern_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        slot_stb, frame_stb, algo_two, step_up_req, step_dn_req;
  logic [2:0]  mode_sel;
  logic [15:0] pwr_err;
  logic        tpc_bit, tpc_vld;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  always #5 clk = ~clk;

  tpc_pattern_gen dut (
    .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .frame_stb(frame_stb),
    .mode_sel(mode_sel), .algo_two(algo_two), .step_up_req(step_up_req),
    .step_dn_req(step_dn_req), .pwr_err(pwr_err), .tpc_bit(tpc_bit), .tpc_vld(tpc_vld)
  );

  // {algo_two, pwr_err, expected bit}: closed loop outside any deadband
  localparam int NV = 9;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 16'sd1,      1'b0},
    {1'b0, -16'sd1,     1'b1},
    {1'b0, 16'sd0,      1'b0},
    {1'b0, 16'sd32767,  1'b0},
    {1'b0, -16'sd32768, 1'b1},
    {1'b0, 16'sd40,     1'b0},
    {1'b1, 16'sd76,     1'b0},
    {1'b1, -16'sd76,    1'b1},
    {1'b1, -16'sd32768, 1'b1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_slot(input logic frm, input logic exp, input string req);
    logic held;
    @(negedge clk);
    slot_stb  = 1'b1;
    frame_stb = frm;
    @(negedge clk);
    slot_stb  = 1'b0;
    frame_stb = 1'b0;
    check("R1 valid pulse", tpc_vld, 1'b1);
    check(req, tpc_bit, exp);
    held = tpc_bit;
    @(negedge clk);
    check("R1 valid low", tpc_vld, 1'b0);
    check("R1 bit held", tpc_bit, held);
  endtask

  task automatic pulse_req(input logic up, input logic dn);
    @(negedge clk);
    step_up_req = up;
    step_dn_req = dn;
    @(negedge clk);
    step_up_req = 1'b0;
    step_dn_req = 1'b0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; slot_stb = 1'b0; frame_stb = 1'b0; mode_sel = 3'd1;
    algo_two = 1'b0; step_up_req = 1'b0; step_dn_req = 1'b0; pwr_err = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset valid", tpc_vld, 1'b0);
    check("R1 reset bit", tpc_bit, 1'b0);

    // R4: alternation starts with up
    do_slot(1'b0, 1'b1, "R4 alt");
    do_slot(1'b0, 1'b0, "R4 alt");
    do_slot(1'b0, 1'b1, "R4 alt");
    do_slot(1'b0, 1'b0, "R4 alt");

    // R3: deadband with algorithm two (phase now up)
    mode_sel = 3'd0; algo_two = 1'b1;
    pwr_err = 16'sd50;  do_slot(1'b0, 1'b1, "R3 in band");
    pwr_err = -16'sd75; do_slot(1'b0, 1'b0, "R3 band edge");
    pwr_err = 16'sd76;  do_slot(1'b0, 1'b0, "R3 above band");
    pwr_err = 16'sd0;   do_slot(1'b0, 1'b1, "R3 zero in band");

    // R2/R3 table walk, phase now down
    for (int i = 0; i < NV; i++) begin
      algo_two = VEC[i][17];
      pwr_err  = VEC[i][16:1];
      do_slot(1'b0, VEC[i][0], VEC[i][17] ? "R3 vector" : "R2 vector");
    end

    // R5
    mode_sel = 3'd2; do_slot(1'b0, 1'b1, "R5 all up"); do_slot(1'b0, 1'b1, "R5 all up");
    mode_sel = 3'd3; do_slot(1'b0, 1'b0, "R5 all down");
    mode_sel = 3'd6; do_slot(1'b0, 1'b0, "R5 reserved code");

    // R4: phase held across other modes
    mode_sel = 3'd1; algo_two = 1'b0;
    do_slot(1'b0, 1'b0, "R4 phase held");

    // R7: single injected down bit
    pulse_req(1'b0, 1'b1);
    do_slot(1'b0, 1'b0, "R7 injected");
    do_slot(1'b0, 1'b1, "R7 resume");
    do_slot(1'b0, 1'b0, "R7 resume");

    // R9: request outside alternating mode ignored
    mode_sel = 3'd2;
    pulse_req(1'b0, 1'b1);
    do_slot(1'b0, 1'b1, "R9 all up unaffected");
    mode_sel = 3'd1;
    do_slot(1'b0, 1'b1, "R9 no stray step");

    // R10: brief mode change discards pending step
    pulse_req(1'b1, 1'b0);
    @(negedge clk); mode_sel = 3'd3;
    @(negedge clk); mode_sel = 3'd1;
    do_slot(1'b0, 1'b0, "R10 step discarded");

    // R8: five-slot step aligned to the set grid
    algo_two = 1'b1;
    do_slot(1'b1, 1'b1, "R8 frame slot");
    pulse_req(1'b0, 1'b1);
    do_slot(1'b0, 1'b0, "R8 wait pos1");
    do_slot(1'b0, 1'b1, "R8 wait pos2");
    do_slot(1'b0, 1'b0, "R8 wait pos3");
    do_slot(1'b0, 1'b1, "R8 wait pos4");
    for (int k = 0; k < 5; k++) do_slot(1'b0, 1'b0, "R8 burst");
    do_slot(1'b0, 1'b0, "R8 resume");
    do_slot(1'b0, 1'b1, "R8 resume");

    // R9: simultaneous requests, up wins
    algo_two = 1'b0;
    pulse_req(1'b1, 1'b1);
    do_slot(1'b0, 1'b1, "R9 up wins");
    do_slot(1'b0, 1'b0, "R9 resume");

    // R6: ten/ten pattern, wrap and mid-run frame restart
    mode_sel = 3'd4;
    do_slot(1'b1, 1'b1, "R6 frame start");
    for (int k = 1; k < 20; k++) do_slot(1'b0, (k < 10), "R6 pattern");
    do_slot(1'b0, 1'b1, "R6 wrap");
    for (int k = 1; k < 12; k++) do_slot(1'b0, (k < 10), "R6 pattern");
    do_slot(1'b1, 1'b1, "R6 restart");
    do_slot(1'b0, 1'b1, "R6 after restart");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule